// File: doc/BRIEF.md
# Fork/join task dispatcher for parallel instruction streams

This block forks a group of data-parallel case tasks across a small pool of hardware instruction streams and joins them again. An executing stream hands the block a parallel-select group, one case task per beat, over a valid/ready intake. Each beat carries a PE selection mask, a start address and a last flag. The first beat also names the issuing stream. The issuing stream surrenders control to the manager. The manager then dispatches the cases in order, each to the lowest-numbered stream that is not executing, and waits whenever every stream is busy. Instruction execution itself is outside the block. A stream reports the end of its case with a one-cycle done pulse.

Every PE owns a small register that names the stream it listens to. When a case is dispatched, the PEs of the issuing group that are selected by that case's mask retarget to the case's stream. A PE that an earlier case of the same group has already taken keeps that earlier stream. Once no case remains and no stream is executing, the block joins the group. The stream whose done came last resumes the program, and every PE of the group listens to it.

Top module: `task_fork_ctrl`

## Requirements
- R1: After reset, every PE stream-ID reads 0, stream 0 is the only busy stream (`is_busy` = 3'b001 at defaults), `task_ready` is 1, and neither `disp_valid` nor `join_valid` is asserted.
- R2: `task_ready` is 1 exactly while the manager is idle. A beat is taken on a clock edge where `task_valid` and `task_ready` are both 1. The issuing stream comes from the first beat of a group, and the `task_issuer` field of every later beat is ignored. A taken beat with `task_last` = 1 ends the intake.
- R3: Cases are dispatched in intake order, at most one per cycle. Each case goes to the lowest-numbered stream whose `is_busy` bit is 0, and the issuing stream counts as free once it has surrendered. The first dispatch is visible in the cycle after the edge that took the final beat. `disp_addr` carries the case's start address, and the chosen stream is busy from the next cycle on.
- R4: On a dispatch, a PE retargets to `disp_is` only if three conditions hold: its mask bit is 1, it listened to the issuing stream when the group was taken, and no earlier case of the group has claimed it. PEs that no case selects keep the issuing stream. PE IDs change only on a dispatch or a join.
- R5: While cases remain and every stream is busy, nothing is dispatched. A done from a busy stream frees it, and the next case is dispatched to that stream two cycles after the edge that took the done.
- R6: A done pulse counts only from a busy stream while a group is open. A done from an idle or surrendered stream, or a done while the manager is idle, leaves `is_busy` unchanged and produces no join.
- R7: The join fires when no case remains and no stream is busy. `join_valid` is high for one cycle, two cycles after the edge that took the final done. `join_is` names the stream whose done was taken last, and the highest index wins when several dones are taken on the same edge. After the join, only that stream is busy, every PE of the group reads `join_is`, and `task_ready` is 1 again.
- R8: A group holds at most MAX_TASKS cases. The MAX_TASKS-th beat (the 4th at defaults) ends the intake even when `task_last` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_valid | input | 1 | A case beat is offered |
| task_ready | output | 1 | Intake open (manager idle) |
| task_issuer | input | IS_W | Issuing stream, read from the first beat only |
| task_cond | input | NUM_PE | PE selection mask of the case |
| task_addr | input | ADDR_W | Start address of the case |
| task_last | input | 1 | Final case of the group |
| is_done | input | NUM_IS | Per-stream end-of-case pulse |
| disp_valid | output | 1 | A case is dispatched this cycle |
| disp_is | output | IS_W | Stream receiving the case |
| disp_addr | output | ADDR_W | Start address handed to that stream |
| join_valid | output | 1 | Group joined this cycle |
| join_is | output | IS_W | Stream that resumes after the join |
| is_busy | output | NUM_IS | Per-stream executing flag |
| pe_is_flat | output | NUM_PE*IS_W | PE stream IDs, PE p at bits [p*IS_W +: IS_W] |

## Verification
The intake has no stall beyond `task_ready`. The first dispatch is due in the cycle after the edge that took the final beat, and each further free stream takes one case per cycle after that. A case held back by busy streams goes out two cycles after the edge that took the freeing done. The join is due two cycles after the edge that took the final done. Dispatch and join events are therefore not checked at fixed times. A monitor compares them at every falling edge against expectation queues that the driver fills beforehand. Each phase then waits well past the latest due cycle and checks that the queues are empty and that the busy flags and PE IDs have settled at their expected values.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [1:0] {
    TM_IDLE,
    TM_ALLOC,
    TM_WAIT,
    TM_JOIN
  } tm_state_e;

  typedef enum logic [1:0] {
    IS_IDLE,
    IS_CALL,
    IS_EXEC
  } is_state_e;
endpackage

// File: rtl/tfc_task_file.sv
module tfc_task_file #(
  parameter int NUM_PE = 8,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NUM_PE-1:0] wr_cond,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NUM_PE-1:0] rd_cond,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [NUM_PE-1:0] cond_mem [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cond_mem[wr_idx] <= wr_cond;
      addr_mem[wr_idx] <= wr_addr;
    end
  end

  assign rd_cond = cond_mem[rd_idx];
  assign rd_addr = addr_mem[rd_idx];
endmodule

// File: rtl/tfc_stream.sv
module tfc_stream
  import tfc_pkg::*;
#(
  parameter bit BOOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grab,
  input  logic launch,
  input  logic done,
  input  logic tm_active,
  input  logic join_go,
  input  logic resume,
  output logic busy,
  output logic done_ok
);
  is_state_e state;

  assign busy    = (state == IS_EXEC);
  assign done_ok = done && tm_active && (state == IS_EXEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BOOT ? IS_EXEC : IS_IDLE;
    end else begin
      case (state)
        IS_IDLE: if (launch) state <= IS_EXEC;
        IS_CALL: begin
          if (launch)       state <= IS_EXEC;
          else if (join_go) state <= resume ? IS_EXEC : IS_IDLE;
        end
        IS_EXEC: if (grab || done_ok) state <= IS_CALL;
        default: state <= IS_IDLE;
      endcase
    end
  end

  AST_IGNORED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tm_active && !grab && !join_go && !launch) |=> $stable(state)); // R6
endmodule

// File: rtl/tfc_manager.sv
module tfc_manager
  import tfc_pkg::*;
#(
  parameter int NUM_IS    = 3,
  parameter int MAX_TASKS = 4,
  localparam int IS_W  = (NUM_IS > 1) ? $clog2(NUM_IS) : 1,
  localparam int IDX_W = (MAX_TASKS > 1) ? $clog2(MAX_TASKS) : 1,
  localparam int CNT_W = $clog2(MAX_TASKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_valid,
  input  logic              task_last,
  input  logic [IS_W-1:0]   task_issuer,
  input  logic [NUM_IS-1:0] is_busy,
  input  logic [NUM_IS-1:0] done_ok,
  output logic              task_ready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [NUM_IS-1:0] grab,
  output logic              capture,
  output logic [IS_W-1:0]   cap_is,
  output logic              disp_valid,
  output logic [IS_W-1:0]   disp_is,
  output logic              join_valid,
  output logic [IS_W-1:0]   join_is,
  output logic              active
);
  tm_state_e        state, state_n;
  logic [CNT_W-1:0] fill_q, next_q;
  logic [IS_W-1:0]  issuer_q, last_q, last_n;
  logic             accept, end_beat, rem, free_hit;
  logic [IS_W-1:0]  free_id;

  assign task_ready = (state == TM_IDLE);
  assign accept     = task_valid && task_ready;
  assign end_beat   = accept && (task_last || fill_q == CNT_W'(MAX_TASKS - 1));
  assign wr_en      = accept;
  assign wr_idx     = fill_q[IDX_W-1:0];
  assign rd_idx     = next_q[IDX_W-1:0];
  assign rem        = (next_q < fill_q);
  assign cap_is     = (fill_q == '0) ? task_issuer : issuer_q;
  assign capture    = end_beat;
  assign active     = (state != TM_IDLE);
  assign join_valid = (state == TM_JOIN);
  assign join_is    = last_q;
  assign disp_valid = (state == TM_ALLOC) && rem && free_hit;
  assign disp_is    = free_id;

  always_comb begin
    free_hit = 1'b0;
    free_id  = '0;
    for (int i = NUM_IS - 1; i >= 0; i--) begin
      if (!is_busy[i]) begin
        free_hit = 1'b1;
        free_id  = IS_W'(i);
      end
    end
  end

  always_comb begin
    last_n = last_q;
    for (int i = 0; i < NUM_IS; i++) begin
      if (done_ok[i]) last_n = IS_W'(i);
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IS; i++) begin
      grab[i] = end_beat && (cap_is == IS_W'(i));
    end
  end

  always_comb begin
    state_n = state;
    case (state)
      TM_IDLE:  if (end_beat) state_n = TM_ALLOC;
      TM_ALLOC: begin
        if (!disp_valid)                       state_n = TM_WAIT;
        else if (next_q + CNT_W'(1) == fill_q) state_n = TM_WAIT;
      end
      TM_WAIT: begin
        if (rem && free_hit)          state_n = TM_ALLOC;
        else if (!rem && !(|is_busy)) state_n = TM_JOIN;
      end
      TM_JOIN:  state_n = TM_IDLE;
      default:  state_n = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TM_IDLE;
      fill_q   <= '0;
      next_q   <= '0;
      issuer_q <= '0;
      last_q   <= '0;
    end else begin
      state  <= state_n;
      last_q <= last_n;
      if (accept) begin
        fill_q <= fill_q + CNT_W'(1);
        if (fill_q == '0) issuer_q <= task_issuer;
      end
      if (end_beat)   next_q <= '0;
      if (disp_valid) next_q <= next_q + CNT_W'(1);
      if (join_valid) fill_q <= '0;
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    task_ready |-> (!disp_valid && !join_valid)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (fill_q < CNT_W'(MAX_TASKS))); // R8
endmodule

// File: rtl/tfc_pe_ids.sv
module tfc_pe_ids #(
  parameter int NUM_PE = 8,
  parameter int NUM_IS = 3,
  localparam int IS_W = (NUM_IS > 1) ? $clog2(NUM_IS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [IS_W-1:0]        cap_is,
  input  logic                   disp_valid,
  input  logic [IS_W-1:0]        disp_is,
  input  logic [NUM_PE-1:0]      disp_cond,
  input  logic                   join_valid,
  input  logic [IS_W-1:0]        join_is,
  output logic [NUM_PE*IS_W-1:0] pe_is_flat
);
  logic [IS_W-1:0]   pe_id [NUM_PE];
  logic [NUM_PE-1:0] member, claimed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PE; p++) pe_id[p] <= '0;
      member  <= '0;
      claimed <= '0;
    end else begin
      for (int p = 0; p < NUM_PE; p++) begin
        if (capture) begin
          member[p]  <= (pe_id[p] == cap_is);
          claimed[p] <= 1'b0;
        end else if (disp_valid && disp_cond[p] && member[p] && !claimed[p]) begin
          pe_id[p]   <= disp_is;
          claimed[p] <= 1'b1;
        end else if (join_valid && member[p]) begin
          pe_id[p]  <= join_is;
          member[p] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_flat
    assign pe_is_flat[g*IS_W +: IS_W] = pe_id[g];
  end

  AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_valid && !join_valid) |=> $stable(pe_is_flat)); // R4
endmodule

// File: rtl/task_fork_ctrl.sv
module task_fork_ctrl #(
  parameter int NUM_IS    = 3,
  parameter int NUM_PE    = 8,
  parameter int MAX_TASKS = 4,
  parameter int ADDR_W    = 8,
  localparam int IS_W  = (NUM_IS > 1) ? $clog2(NUM_IS) : 1,
  localparam int IDX_W = (MAX_TASKS > 1) ? $clog2(MAX_TASKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   task_valid,
  output logic                   task_ready,
  input  logic [IS_W-1:0]        task_issuer,
  input  logic [NUM_PE-1:0]      task_cond,
  input  logic [ADDR_W-1:0]      task_addr,
  input  logic                   task_last,
  input  logic [NUM_IS-1:0]      is_done,
  output logic                   disp_valid,
  output logic [IS_W-1:0]        disp_is,
  output logic [ADDR_W-1:0]      disp_addr,
  output logic                   join_valid,
  output logic [IS_W-1:0]        join_is,
  output logic [NUM_IS-1:0]      is_busy,
  output logic [NUM_PE*IS_W-1:0] pe_is_flat
);
  logic              wr_en, capture, active;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [NUM_IS-1:0] grab, done_ok;
  logic [IS_W-1:0]   cap_is;
  logic [NUM_PE-1:0] rd_cond;

  tfc_task_file #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DEPTH(MAX_TASKS)) u_file (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cond(task_cond),
    .wr_addr(task_addr), .rd_idx(rd_idx), .rd_cond(rd_cond), .rd_addr(disp_addr)
  );

  tfc_manager #(.NUM_IS(NUM_IS), .MAX_TASKS(MAX_TASKS)) u_mgr (
    .clk(clk), .rst_n(rst_n), .task_valid(task_valid), .task_last(task_last),
    .task_issuer(task_issuer), .is_busy(is_busy), .done_ok(done_ok),
    .task_ready(task_ready), .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .grab(grab), .capture(capture), .cap_is(cap_is), .disp_valid(disp_valid),
    .disp_is(disp_is), .join_valid(join_valid), .join_is(join_is), .active(active)
  );

  for (genvar s = 0; s < NUM_IS; s++) begin : g_stream
    tfc_stream #(.BOOT(s == 0)) u_stream (
      .clk(clk), .rst_n(rst_n), .grab(grab[s]),
      .launch(disp_valid && (disp_is == IS_W'(s))),
      .done(is_done[s]), .tm_active(active), .join_go(join_valid),
      .resume(join_is == IS_W'(s)), .busy(is_busy[s]), .done_ok(done_ok[s])
    );
  end

  tfc_pe_ids #(.NUM_PE(NUM_PE), .NUM_IS(NUM_IS)) u_pe (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_is(cap_is),
    .disp_valid(disp_valid), .disp_is(disp_is), .disp_cond(rd_cond),
    .join_valid(join_valid), .join_is(join_is), .pe_is_flat(pe_is_flat)
  );

  AST_DISP_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !is_busy[disp_is]); // R3
  AST_DISP_TAKES_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> is_busy[$past(disp_is)]); // R3
  AST_JOIN_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    join_valid |-> (is_busy == '0)); // R7
  AST_JOIN_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    join_valid |=> ($countones(is_busy) == 1 && is_busy[$past(join_is)])); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && join_valid)); // R7
endmodule

// File: tb/test_task_fork_ctrl.sv
module test_task_fork_ctrl;
  localparam int NUM_IS = 3;
  localparam int NUM_PE = 8;
  localparam int ADDR_W = 8;
  localparam int IS_W   = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   task_valid = 1'b0;
  logic                   task_ready;
  logic [IS_W-1:0]        task_issuer = '0;
  logic [NUM_PE-1:0]      task_cond = '0;
  logic [ADDR_W-1:0]      task_addr = '0;
  logic                   task_last = 1'b0;
  logic [NUM_IS-1:0]      is_done = '0;
  logic                   disp_valid;
  logic [IS_W-1:0]        disp_is;
  logic [ADDR_W-1:0]      disp_addr;
  logic                   join_valid;
  logic [IS_W-1:0]        join_is;
  logic [NUM_IS-1:0]      is_busy;
  logic [NUM_PE*IS_W-1:0] pe_is_flat;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int dq_is[$];
  int dq_addr[$];
  int jq[$];

  task_fork_ctrl i_task_fork_ctrl (
    .clk(clk), .rst_n(rst_n), .task_valid(task_valid), .task_ready(task_ready),
    .task_issuer(task_issuer), .task_cond(task_cond), .task_addr(task_addr),
    .task_last(task_last), .is_done(is_done), .disp_valid(disp_valid),
    .disp_is(disp_is), .disp_addr(disp_addr), .join_valid(join_valid),
    .join_is(join_is), .is_busy(is_busy), .pe_is_flat(pe_is_flat)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_pes(input string req, input int exp_id [NUM_PE]);
    for (int p = 0; p < NUM_PE; p++)
      check(req, $sformatf("pe%0d stream id", p), int'(pe_is_flat[p*IS_W +: IS_W]), exp_id[p]);
  endtask

  task automatic send_beat(input int issuer, input int cond, input int addr, input bit last);
    do @(negedge clk); while (!task_ready);
    task_valid  = 1'b1;
    task_issuer = IS_W'(issuer);
    task_cond   = NUM_PE'(cond);
    task_addr   = ADDR_W'(addr);
    task_last   = last;
    @(posedge clk);
    @(negedge clk);
    task_valid = 1'b0;
    task_last  = 1'b0;
  endtask

  task automatic pulse_done(input int mask);
    @(negedge clk);
    is_done = NUM_IS'(mask);
    @(negedge clk);
    is_done = '0;
  endtask

  task automatic expect_disp(input int s, input int a);
    dq_is.push_back(s);
    dq_addr.push_back(a);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (disp_valid) begin
        if (dq_is.size() == 0) begin
          check("R3", "unexpected dispatch stream", int'(disp_is), -1);
        end else begin
          int es, ea;
          es = dq_is.pop_front();
          ea = dq_addr.pop_front();
          check("R3", "dispatch stream", int'(disp_is), es);
          check("R3", "dispatch address", int'(disp_addr), ea);
        end
      end
      if (join_valid) begin
        if (jq.size() == 0) begin
          check("R7", "unexpected join stream", int'(join_is), -1);
        end else begin
          int ej;
          ej = jq.pop_front();
          check("R7", "join stream", int'(join_is), ej);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pe_exp [NUM_PE];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "task_ready", int'(task_ready), 1);
    check("R1", "is_busy", int'(is_busy), 1);
    check("R1", "disp_valid", int'(disp_valid), 0);
    check("R1", "join_valid", int'(join_valid), 0);
    pe_exp = '{default: 0};
    check_pes("R1", pe_exp);

    // Phase 1: three cases from stream 0, overlapping masks
    expect_disp(0, 8'h10);
    expect_disp(1, 8'h20);
    expect_disp(2, 8'h30);
    send_beat(0, 8'h03, 8'h10, 1'b0);
    send_beat(0, 8'h0E, 8'h20, 1'b0);
    send_beat(0, 8'h30, 8'h30, 1'b1);
    idle_cycles(5);
    check("R3", "phase1 dispatches pending", dq_is.size(), 0);
    check("R3", "phase1 all streams busy", int'(is_busy), 7);
    check("R2", "intake closed during group", int'(task_ready), 0);
    pe_exp = '{0, 0, 1, 1, 2, 2, 0, 0};
    check_pes("R4", pe_exp);
    pulse_done(1);
    pulse_done(2);
    idle_cycles(3);
    check("R6", "busy after two dones", int'(is_busy), 4);
    check("R7", "no early join", jq.size(), 0);
    jq.push_back(2);
    pulse_done(4);
    idle_cycles(4);
    check("R7", "phase1 join pending", jq.size(), 0);
    check("R7", "owner busy after join", int'(is_busy), 4);
    check("R7", "intake reopened", int'(task_ready), 1);
    pe_exp = '{default: 2};
    check_pes("R7", pe_exp);

    // Phase 2: done while manager idle is ignored
    pulse_done(4);
    idle_cycles(3);
    check("R6", "idle-manager done ignored busy", int'(is_busy), 4);
    check("R6", "idle-manager done no join", int'(join_valid), 0);

    // Phase 3: four beats without last from stream 2, later issuer fields 1
    expect_disp(0, 8'h40);
    expect_disp(1, 8'h41);
    expect_disp(2, 8'h42);
    expect_disp(1, 8'h43);
    send_beat(2, 8'h01, 8'h40, 1'b0);
    send_beat(1, 8'h02, 8'h41, 1'b0);
    send_beat(1, 8'h04, 8'h42, 1'b0);
    send_beat(1, 8'h08, 8'h43, 1'b0);
    idle_cycles(6);
    check("R8", "fourth beat closes intake", int'(task_ready), 0);
    check("R5", "case held while all busy", dq_is.size(), 1);
    check("R5", "all streams busy", int'(is_busy), 7);
    pe_exp = '{0, 1, 2, 2, 2, 2, 2, 2};
    check_pes("R2", pe_exp);
    pulse_done(2);
    idle_cycles(4);
    check("R5", "held case dispatched to freed stream", dq_is.size(), 0);
    pe_exp = '{0, 1, 2, 1, 2, 2, 2, 2};
    check_pes("R4", pe_exp);
    pulse_done(1);
    idle_cycles(2);
    check("R6", "busy after stream0 done", int'(is_busy), 6);
    pulse_done(1);
    idle_cycles(2);
    check("R6", "repeat done on free stream ignored", int'(is_busy), 6);
    jq.push_back(2);
    pulse_done(6);
    idle_cycles(4);
    check("R7", "tie join pending", jq.size(), 0);
    check("R7", "tie owner busy", int'(is_busy), 4);
    pe_exp = '{default: 2};
    check_pes("R7", pe_exp);

    // Phase 4: single case, empty mask, last on first beat
    expect_disp(0, 8'h55);
    send_beat(2, 8'h00, 8'h55, 1'b1);
    idle_cycles(3);
    check("R3", "single dispatch pending", dq_is.size(), 0);
    check("R3", "single case stream busy", int'(is_busy), 1);
    check_pes("R4", pe_exp);
    jq.push_back(0);
    pulse_done(1);
    idle_cycles(4);
    check("R7", "single join pending", jq.size(), 0);
    check("R7", "stream0 resumes", int'(is_busy), 1);
    pe_exp = '{default: 0};
    check_pes("R7", pe_exp);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule